// File: doc/BRIEF.md
# Pipeline ADC Digital Error Correction

This block is the digital back end of a nine-stage pipelined analog-to-digital converter. Eight redundant subconverter stages each resolve a 2-bit decision that carries one bit of overlap. A last 2-bit flash stage closes the chain. Because neighbouring stages work on opposite clock phases, each stage's decision for one sample reaches the block at a different time. The block holds each decision in a delay line sized for its stage. Once all nine decisions for a sample have arrived, it lines them up and adds them with overlapping weights into a 10-bit word. The overlap absorbs comparator offsets in the analog stages.

The corrected word is coded at run time as either offset binary or two's complement. It then passes through an internal holding register into the output register, so each sample's word reaches the bus a fixed number of clocks after the sample strobe. A sample can be started on every clock. A decision value that no redundant stage can legally produce is clipped to the largest legal value and recorded in a sticky error flag.

Top module: `adc_pipe_corrector`

## Requirements
- R1: A sample strobed on `sample_i` at rising edge t appears on `word_o` after rising edge t+7. `word_vld_o` is high for exactly that one cycle per sample.
- R2: The offset-binary word equals the sum over stages k = 1..8 of d_k·2^(9−k), plus the flash code f. Here d_k is the stage-k decision and f is `flash_code_i`. The result spans 0 to 1023, so no clipping is needed.
- R3: Stage k (1..8) is read from bits [2k−1:2k−2] of `stage_codes_i`. Stages 2m−1 and 2m are taken m−1 cycles after the strobe (m = 1..4), and the flash code 4 cycles after it. Values on these inputs outside their slot change neither the output nor the error flag.
- R4: Samples may be strobed on consecutive clocks. One corrected word then leaves on every clock, in strobe order.
- R5: `fmt_twos_i` is sampled at edge t+6 for the sample strobed at edge t. Low gives offset binary. High gives two's complement, which is the offset-binary word with bit 9 inverted.
- R6: `word_o` changes only on cycles where `word_vld_o` is high. Otherwise it keeps the last word.
- R7: A redundant-stage decision of 3 enters the sum as 2.
- R8: A decision of 3 on a redundant stage, taken within its slot, sets `code_err_o` after that edge. The flag stays set until reset.
- R9: A synchronous active-low reset clears `word_o`, `word_vld_o` and `code_err_o` to 0 and discards every sample strobed before or during the reset cycle.
- R10: Suppose each stage's two comparator thresholds are off by less than one eighth of full scale and the flash stage is ideal. Then the output equals an ideal 10-bit quantiser of the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_i | input | 1 | Strobe marking the cycle a sample is taken |
| fmt_twos_i | input | 1 | Output coding: 0 offset binary, 1 two's complement |
| stage_codes_i | input | 16 | Decisions of the eight redundant stages, stage k at bits [2k−1:2k−2] |
| flash_code_i | input | 2 | Decision of the final flash stage |
| word_o | output | 10 | Corrected and formatted output word |
| word_vld_o | output | 1 | High for the cycle a new word is on `word_o` |
| code_err_o | output | 1 | Sticky flag for an illegal redundant-stage decision |

## Verification
The checker watches four things on every cycle. Valid output must trail the strobe by exactly seven clocks. The output must stay still between valid words. The output's top bit must be the registered sum's top bit flipped by the format input, with the lower bits passed through unchanged. The error flag must set after an in-slot illegal first-stage decision and must never clear. Other behaviour can only be shown by the bench's scenarios: that the correction reproduces an ideal quantiser when comparators are offset, that junk outside the arrival slots is ignored, that illegal decisions are clipped to 2 in the sum, and that a reset mid-stream discards the samples in flight.

// File: rtl/adc_corr_pkg.sv
// Shared constants and types for the pipeline ADC digital correction block.
// Assumes 1.5-bit redundant stages (legal decisions 0..2) followed by one
// plain 2-bit flash stage.
package adc_corr_pkg;

    localparam int RED_STAGES_DEF = 8;                   // redundant stages
    localparam int CODE_W_DEF     = 2;                   // bits per decision
    localparam int WORD_W_DEF     = RED_STAGES_DEF + 2;  // corrected width

    // Two redundant stages share each arrival slot; the flash code comes one slot later.
    function automatic int slots_for(input int stages);
        return stages / 2;
    endfunction

endpackage

// File: rtl/adc_delay_line.sv
// Fixed-depth shift register holding one stage decision until the rest of
// its sample has arrived.
// Assumes DEPTH >= 1. It shifts on every clock, and reset empties all taps.
module adc_delay_line #(
    parameter int WIDTH = 2,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] tap_q [DEPTH];

    // Advance every tap by one position per clock; reset clears them all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tap_q[i] <= '0;
            end
        end else begin
            tap_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                tap_q[i] <= tap_q[i-1];
            end
        end
    end

    assign dout = tap_q[DEPTH-1];

endmodule

// File: rtl/adc_code_clamp.sv
// Clips a redundant-stage decision to its legal range and reports values
// above that range.
// Assumes the largest legal decision is 2^CODE_W - 2. An out-of-range value
// is reported only while its arrival slot is active.
module adc_code_clamp #(
    parameter int CODE_W = 2
) (
    input  logic [CODE_W-1:0] raw_i,
    input  logic              slot_vld_i,
    output logic [CODE_W-1:0] code_o,
    output logic              illegal_o
);

    localparam logic [CODE_W-1:0] TOP_LEGAL = CODE_W'((1 << CODE_W) - 2);

    logic over_range;

    // Compare once and reuse the result for the clip and the report.
    always_comb begin
        over_range = (raw_i > TOP_LEGAL);
        code_o     = over_range ? TOP_LEGAL : raw_i;
        illegal_o  = over_range && slot_vld_i;
    end

endmodule

// File: rtl/adc_overlap_sum.sv
// Overlap-add correction: adds the aligned decisions with each stage's
// weight at twice the next stage's weight, then registers the word.
// Assumes decisions are already clipped. Stage k (0-based) carries weight
// 2^(N-k) and the flash code carries weight 1, so N+2 bits hold the maximum.
module adc_overlap_sum #(
    parameter int N      = 8,
    parameter int CODE_W = 2,
    parameter int WORD_W = N + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N*CODE_W-1:0]   codes_i,
    input  logic [CODE_W-1:0]     flash_i,
    input  logic                  vld_i,
    output logic [WORD_W-1:0]     sum_o,
    output logic                  vld_o
);

    logic [WORD_W-1:0] part [N+1];

    assign part[0] = WORD_W'(flash_i);

    generate
        for (genvar k = 0; k < N; k++) begin : g_term
            // Add stage k's weighted decision to the partial sum.
            assign part[k+1] = part[k]
                             + (WORD_W'(codes_i[k*CODE_W +: CODE_W]) << (N - k));
        end
    endgenerate

    // Register the corrected word whenever an aligned sample is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_o <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                sum_o <= part[N];
            end
        end
    end

endmodule

// File: rtl/adc_out_stage.sv
// Formats the corrected word and passes it through an internal holding
// register into the output register, so the bus changes at most once a clock.
// Assumes offset-binary input. Two's complement is formed by flipping the MSB
// as the word enters the holding register.
module adc_out_stage #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] sum_i,
    input  logic              vld_i,
    input  logic              fmt_twos_i,
    output logic [WORD_W-1:0] word_o,
    output logic              vld_o
);

    logic [WORD_W-1:0] hold_q;
    logic              hold_vld_q;

    // Capture a newly corrected word, applying the coding selected this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= '0;
            hold_vld_q <= 1'b0;
        end else begin
            hold_vld_q <= vld_i;
            if (vld_i) begin
                hold_q <= {sum_i[WORD_W-1] ^ fmt_twos_i, sum_i[WORD_W-2:0]};
            end
        end
    end

    // Move the held word to the bus; keep the old word when nothing is new.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= hold_vld_q;
            if (hold_vld_q) begin
                word_o <= hold_q;
            end
        end
    end

endmodule

// File: rtl/adc_pipe_corrector.sv
// Digital back end of a pipelined ADC. It aligns the staggered decisions of
// the redundant stages and the flash stage, corrects them by overlap-add,
// formats the word and double-buffers it onto the bus.
// Assumes stages 2m-1 and 2m are presented m-1 cycles after sample_i and the
// flash code RED_STAGES/2 cycles after it. Total latency is RED_STAGES/2 + 3.
module adc_pipe_corrector
    import adc_corr_pkg::*;
#(
    parameter int RED_STAGES = RED_STAGES_DEF,
    parameter int CODE_W     = CODE_W_DEF,
    parameter int WORD_W     = RED_STAGES + 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sample_i,
    input  logic                         fmt_twos_i,
    input  logic [RED_STAGES*CODE_W-1:0] stage_codes_i,
    input  logic [CODE_W-1:0]            flash_code_i,
    output logic [WORD_W-1:0]            word_o,
    output logic                         word_vld_o,
    output logic                         code_err_o
);

    localparam int SLOTS = slots_for(RED_STAGES);   // arrival slots of stage pairs

    // stb_q[i] is the sample strobe delayed by i+1 clocks.
    logic [SLOTS:0]                 stb_q;
    logic [SLOTS-1:0]               slot_vld;
    logic [RED_STAGES-1:0]          illegal;
    logic [RED_STAGES*CODE_W-1:0]   clipped;
    logic [RED_STAGES*CODE_W-1:0]   aligned;
    logic [CODE_W-1:0]              flash_aligned;
    logic                           code_err_q;
    logic [WORD_W-1:0]              sum_word;
    logic                           sum_vld;

    // Track which samples are in flight so each arrival slot knows it is live.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= '0;
        end else begin
            stb_q <= {stb_q[SLOTS-1:0], sample_i};
        end
    end

    assign slot_vld = {stb_q[SLOTS-2:0], sample_i};

    generate
        for (genvar s = 0; s < RED_STAGES; s++) begin : g_stage
            localparam int SLOT = s / 2;

            adc_code_clamp #(
                .CODE_W (CODE_W)
            ) u_clamp (
                .raw_i      (stage_codes_i[s*CODE_W +: CODE_W]),
                .slot_vld_i (slot_vld[SLOT]),
                .code_o     (clipped[s*CODE_W +: CODE_W]),
                .illegal_o  (illegal[s])
            );

            // Earlier stages wait longer so all decisions line up with the flash code.
            adc_delay_line #(
                .WIDTH (CODE_W),
                .DEPTH (SLOTS + 1 - SLOT)
            ) u_delay (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (clipped[s*CODE_W +: CODE_W]),
                .dout  (aligned[s*CODE_W +: CODE_W])
            );
        end
    endgenerate

    adc_delay_line #(
        .WIDTH (CODE_W),
        .DEPTH (1)
    ) u_flash_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (flash_code_i),
        .dout  (flash_aligned)
    );

    // Latch any in-slot illegal decision until the next reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_err_q <= 1'b0;
        end else if (|illegal) begin
            code_err_q <= 1'b1;
        end
    end

    assign code_err_o = code_err_q;

    adc_overlap_sum #(
        .N      (RED_STAGES),
        .CODE_W (CODE_W),
        .WORD_W (WORD_W)
    ) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .codes_i (aligned),
        .flash_i (flash_aligned),
        .vld_i   (stb_q[SLOTS]),
        .sum_o   (sum_word),
        .vld_o   (sum_vld)
    );

    adc_out_stage #(
        .WORD_W (WORD_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .sum_i      (sum_word),
        .vld_i      (sum_vld),
        .fmt_twos_i (fmt_twos_i),
        .word_o     (word_o),
        .vld_o      (word_vld_o)
    );

endmodule

// File: rtl/adc_pipe_corrector_chk.sv
// Property checker for adc_pipe_corrector, attached by bind. It keeps its
// own strobe history and a count of clocks since reset, so no property looks
// back across a reset.
module adc_pipe_corrector_chk #(
    parameter int RED_STAGES = 8,
    parameter int CODE_W     = 2,
    parameter int WORD_W     = RED_STAGES + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_i,
    input logic              fmt_twos_i,
    input logic [CODE_W-1:0] first_code,
    input logic [WORD_W-1:0] sum_word,
    input logic [WORD_W-1:0] word_o,
    input logic              word_vld_o,
    input logic              code_err_o
);

    localparam int LAT = RED_STAGES / 2 + 3;

    logic [LAT:0] stb_hist;
    logic [7:0]   since_rst;

    // Strobe history as seen at the edges, oldest entry at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_hist <= '0;
        end else begin
            stb_hist <= {stb_hist[LAT-1:0], sample_i};
        end
    end

    // Clocks since reset was released, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 8'hFF) begin
            since_rst <= since_rst + 8'd1;
        end
    end

    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst > 8'(LAT + 1)) |-> (word_vld_o == stb_hist[LAT]));

    a_r5_format: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst > 8'd3) && word_vld_o) |->
            ((word_o[WORD_W-1] == ($past(sum_word[WORD_W-1], 2) ^ $past(fmt_twos_i, 2)))
             && (word_o[WORD_W-2:0] == $past(sum_word[WORD_W-2:0], 2))));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst > 8'd1) && !word_vld_o) |-> $stable(word_o));

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        code_err_o |=> code_err_o);

    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && (first_code == '1)) |=> code_err_o);

    a_r9_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 8'd0) |-> (!word_vld_o && (word_o == '0) && !code_err_o));

endmodule

bind adc_pipe_corrector adc_pipe_corrector_chk #(
    .RED_STAGES (RED_STAGES),
    .CODE_W     (CODE_W),
    .WORD_W     (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_i   (sample_i),
    .fmt_twos_i (fmt_twos_i),
    .first_code (stage_codes_i[CODE_W-1:0]),
    .sum_word   (sum_word),
    .word_o     (word_o),
    .word_vld_o (word_vld_o),
    .code_err_o (code_err_o)
);

// File: tb/adc_pipe_corrector_tb.sv
// Self-checking bench. Random analog levels go through a behavioural model of
// offset-afflicted redundant stages, mixed with directed code patterns.
// Expected words come from an ideal quantiser or the overlap-add formula.
module adc_pipe_corrector_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NS = 8;
    localparam int CW = 2;
    localparam int WW = 10;
    localparam int NC = 2600;
    localparam int FS = 262144;          // model full scale (2^18)

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_i = 1'b0;
    logic fmt_i = 1'b0;
    logic [NS*CW-1:0] codes = '0;
    logic [CW-1:0] flash = '0;
    logic [WW-1:0] word;
    logic wvld;
    logic err;

    always #4ns clk = ~clk;

    adc_pipe_corrector u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_i      (sample_i),
        .fmt_twos_i    (fmt_i),
        .stage_codes_i (codes),
        .flash_code_i  (flash),
        .word_o        (word),
        .word_vld_o    (wvld),
        .code_err_o    (err)
    );

    int checks = 0;
    int fails = 0;
    int n = 0;
    bit done = 0;

    bit st [NC];
    bit fm [NC];
    bit rs [NC];
    bit bad [NC];
    bit mdl [NC];
    int dq [NC][NS];
    int fq [NC];
    int ev [NC];

    logic [WW-1:0] exp_word = '0;
    bit exp_vld = 0;
    bit exp_err = 0;

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, n, act, expv);
        end
    endtask

    function automatic logic [WW-1:0] fmtw(input int v, input bit twos);
        logic [WW-1:0] w;
        w = WW'(v);
        if (twos) w[WW-1] = ~w[WW-1];
        return w;
    endfunction

    // R2/R7 formula: weighted decisions, a 3 counted as 2, plus flash.
    function automatic int code_sum(input int idx);
        int acc;
        acc = fq[idx];
        for (int k = 0; k < NS; k++) begin
            acc += ((dq[idx][k] > 2) ? 2 : dq[idx][k]) << (NS - k);
        end
        return acc;
    endfunction

    // Offset-afflicted 1.5-bit stages (thresholds 3/8 and 5/8 FS, each off
    // by under FS/8), ideal flash at the end.
    task automatic model(input int x, input int idx);
        int r;
        r = x;
        for (int k = 0; k < NS; k++) begin
            int t1;
            int t2;
            int d;
            t1 = 98304 + int'($urandom_range(0, 65532)) - 32766;
            t2 = 163840 + int'($urandom_range(0, 65532)) - 32766;
            d = ((r >= t1) ? 1 : 0) + ((r >= t2) ? 1 : 0);
            dq[idx][k] = d;
            r = 2 * r - d * (FS / 2);
        end
        fq[idx] = r >> 16;
        ev[idx] = x >> 8;
        mdl[idx] = 1;
    endtask

    // kind: 0 junk, 1 random model, 2 model at xv, 3 all-max codes,
    // 4 all-zero codes, 5 random model with stage xv forced to 3.
    task automatic step(input bit rst_v, input bit strobe, input bit fmt_v,
                        input int kind, input int xv);
        if (n > 0) begin
            int e;
            int s;
            string tag;
            e = n - 1;
            s = e - 7;
            if (!rs[e]) begin
                exp_word = '0;
                exp_vld = 0;
                exp_err = 0;
            end else begin
                exp_vld = (s >= 0) && st[s];
                if (exp_vld) exp_word = fmtw(ev[s], fm[e-1]);
                for (int m = 0; m < NS / 2; m++) begin
                    int j;
                    j = e - m;
                    if (j >= 0 && st[j] && (dq[j][2*m] == 3 || dq[j][2*m+1] == 3))
                        exp_err = 1;
                end
            end
            if (!rs[e]) tag = "R9 reset word";
            else if (!exp_vld) tag = "R6 hold";
            else if (bad[s]) tag = "R7 illegal as two";
            else if (mdl[s]) tag = fm[e-1] ? "R5/R10 twos complement" : "R10 ideal quantiser";
            else tag = fm[e-1] ? "R5/R2 twos complement" : "R2 overlap sum";
            chk(tag, int'(word), int'(exp_word));
            chk(rs[e] ? "R1/R4 word valid" : "R9 reset valid", int'(wvld), int'(exp_vld));
            chk(rs[e] ? "R3/R8 error flag" : "R9 reset error flag", int'(err), int'(exp_err));
        end

        rs[n] = rst_v;
        st[n] = strobe && rst_v;
        fm[n] = fmt_v;
        bad[n] = 0;
        mdl[n] = 0;
        if (!rst_v) begin
            for (int j = ((n > 7) ? n - 7 : 0); j < n; j++) st[j] = 0;
        end
        for (int k = 0; k < NS; k++) dq[n][k] = int'($urandom_range(0, 3));
        fq[n] = int'($urandom_range(0, 3));
        ev[n] = 0;
        if (strobe) begin
            case (kind)
                1: model(int'($urandom_range(0, FS - 1)), n);
                2: model(xv, n);
                3: begin
                    for (int k = 0; k < NS; k++) dq[n][k] = 2;
                    fq[n] = 3;
                    ev[n] = code_sum(n);
                end
                4: begin
                    for (int k = 0; k < NS; k++) dq[n][k] = 0;
                    fq[n] = 0;
                    ev[n] = code_sum(n);
                end
                5: begin
                    model(int'($urandom_range(0, FS - 1)), n);
                    mdl[n] = 0;
                    bad[n] = 1;
                    dq[n][xv] = 3;
                    ev[n] = code_sum(n);
                end
                default: ;
            endcase
        end

        rst_n = rst_v;
        sample_i = strobe;
        fmt_i = fmt_v;
        for (int k = 0; k < NS; k++) begin
            int j;
            j = n - k / 2;
            codes[CW*k +: CW] = CW'((j >= 0) ? dq[j][k] : 0);
        end
        flash = CW'((n >= 4) ? fq[n-4] : 0);
        n++;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1600000ns;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", n);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240));
        @(negedge clk);
        // R9: reset with strobes asserted; they must be ignored.
        for (int i = 0; i < 3; i++) step(0, 1, 0, 1, 0);
        for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 0);
        // R2 corners: all-zero and all-max decisions, both codings.
        step(1, 1, 0, 4, 0);
        step(1, 1, 0, 3, 0);
        step(1, 1, 1, 3, 0);
        step(1, 1, 1, 4, 0);
        // R10 corners: bottom and top of input range.
        step(1, 1, 0, 2, 0);
        step(1, 1, 1, 2, FS - 1);
        step(1, 1, 0, 2, FS / 2);
        for (int i = 0; i < 10; i++) step(1, 0, 1, 0, 0);
        // R4/R5/R10: back-to-back samples with the coding toggling freely.
        for (int i = 0; i < 600; i++) step(1, 1, 1'($urandom_range(0, 1)), 1, 0);
        // R3/R6: sparse samples, junk (including 3s) outside the slots.
        for (int i = 0; i < 400; i++)
            step(1, ($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)), 1, 0);
        for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 0);
        // R7/R8: illegal decision on the last stage, then on the first.
        step(1, 1, 0, 5, 7);
        for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 0);
        step(1, 1, 1, 5, 0);
        for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 0);
        // R9: reset in the middle of a running stream.
        for (int i = 0; i < 20; i++) step(1, 1, 1'($urandom_range(0, 1)), 1, 0);
        step(0, 1, 0, 1, 0);
        step(0, 1, 0, 1, 0);
        for (int i = 0; i < 100; i++) step(1, 1, 1'($urandom_range(0, 1)), 1, 0);
        for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule